// File: doc/BRIEF.md
# SDRAM Command Spacing and Manual Command Unit

This unit sits between an SDRAM command scheduler and the command pins of the memory. The scheduler presents one command at a time (activate, read, write, single-bank precharge or refresh) together with a rank number. The unit answers with a ready signal that stays low until every programmed minimum gap since an earlier related command has passed. Once the command is accepted, the unit drives it onto the chip-select, RAS, CAS, WE and A10 pins for one cycle. For each read or write it also produces a data strobe that fires an exact, programmed number of counts after the command.

Software programs a timing register and a control register. The timing register holds six four-bit fields: four minimum gaps and two exact latencies. Only a power-up reset clears it. The control register enables the unit, turns on the SDRAM clock-enable pin and selects single- or double-rate counting. It also has two write-only request bits: one asks for a precharge-all command and one asks for a refresh command on every rank. In double-rate mode a gap or a latency is counted in ticks of a clock twice as fast as the unit's clock, so each unit cycle uses up two counts.

Top module: `sdcmd_gap_unit`

## Requirements
- R1: The register at select 0 is the timing register. Its bits [3:0] are the read latency, [7:4] the write latency, [11:8] the activate-to-read/write gap, [15:12] the read/write-to-precharge gap, [19:16] the precharge-to-activate gap (it also spaces precharge-to-refresh) and [23:20] the refresh-to-any gap. Bits [31:24] read as zero. The register at select 1 is the control register: bit 0 enables the unit, bit 1 drives the clock-enable pin, bit 2 selects double-rate counting, bit 3 requests a refresh and bit 4 requests a precharge-all. Bits 3 and 4 always read back as zero. Both registers are read combinationally on `reg_rdata`.
- R2: Power-up reset (`por_n` low) clears both registers. System reset (`rst_n` low) clears the control register, the pins and all timers, and leaves the timing register unchanged. After reset every chip select, RAS, CAS and WE are high, A10 is low, clock enable is low and `req_ready` is low.
- R3: In single-rate mode, a command that is gated by a field of value F and follows the command that started the gap is first ready exactly max(F,1) cycles after that command's accept edge. A larger F only lengthens the gap.
- R4: In double-rate mode the same gap is ceil(max(F,1)/2) cycles.
- R5: A field value of zero gives the same gap as a value of one: back-to-back issue on consecutive cycles.
- R6: The read (write) strobe is high for exactly one cycle. In single-rate mode it comes L cycles after the command appears on the pins, where L is the read (write) latency. In double-rate mode it comes floor(L/2) cycles after, and the half flag that goes with it equals L[0].
- R7: A precharge-all or refresh request is honored only when the enable bit and the clock-enable bit were both already 1 before the write. Otherwise it is ignored and produces no pin activity.
- R8: An honored precharge-all drives every chip select low for exactly one cycle, with RAS low, CAS high, WE low and A10 high.
- R9: A control write that sets both request bits pulses `cmd_err` high for one cycle, visible after the write edge, and issues neither command.
- R10: While a gap timer is running, or while a manual request is waiting to go out, `req_ready` is low for upstream commands and the pins stay idle except for the manual command itself. An honored manual command waits until its own gap has expired.
- R11: `req_cmd` codes are 0 none, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh; codes 6 and 7 are treated as none. The pin patterns {RAS,CAS,WE} are 011 for activate, 101 for read, 100 for write, 010 for precharge with A10 low, and 001 for refresh. Only the chip select of `req_rank` goes low.
- R12: An honored refresh request drives every chip select low for one cycle with {RAS,CAS,WE} = 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock (the SDRAM command clock) |
| por_n | input | 1 | Power-up reset, active low, synchronous |
| rst_n | input | 1 | System reset, active low, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 timing, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| req_valid | input | 1 | Scheduler presents a command |
| req_cmd | input | 3 | Command code |
| req_rank | input | 1 | Rank whose chip select is used |
| req_ready | output | 1 | The presented command may go out this cycle |
| cs_n | output | 2 | Chip selects, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | All-bank select for precharge |
| cke | output | 1 | SDRAM clock enable |
| rd_strobe | output | 1 | Read data capture point |
| rd_half | output | 1 | Read capture falls on the second half-cycle |
| wr_strobe | output | 1 | Write data launch point |
| wr_half | output | 1 | Write launch falls on the second half-cycle |
| cmd_err | output | 1 | Conflicting manual request pulse |

## Verification
A gap timer left with the wrong count shows up as `req_ready` rising one or more cycles too early or too late, on the very next related request. The gap sweep measures that rise edge directly for each field value in both counting modes. A corrupted latency pipeline moves the strobe or doubles it within at most fifteen cycles of the command. A stuck manual-request flag either blocks `req_ready` indefinitely or puts an all-rank command on the pins with no request behind it, and either is visible within a few cycles of the control write.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;
  localparam int FIELD_W = 4;
  localparam int REG_W   = 32;
  localparam int N_FIELD = 6;
  localparam int CFG_W   = N_FIELD * FIELD_W;

  localparam logic [2:0] CMD_NOP = 3'd0;
  localparam logic [2:0] CMD_ACT = 3'd1;
  localparam logic [2:0] CMD_RD  = 3'd2;
  localparam logic [2:0] CMD_WR  = 3'd3;
  localparam logic [2:0] CMD_PRE = 3'd4;
  localparam logic [2:0] CMD_REF = 3'd5;

  // gap timer slots
  localparam int TM_RW  = 0;
  localparam int TM_PRE = 1;
  localparam int TM_ACT = 2;
  localparam int TM_REF = 3;
  localparam int N_TM   = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] ref2any;
    logic [FIELD_W-1:0] pre2act;
    logic [FIELD_W-1:0] rw2pre;
    logic [FIELD_W-1:0] act2rw;
    logic [FIELD_W-1:0] wr_lat;
    logic [FIELD_W-1:0] rd_lat;
  } timing_cfg_t;

  // one unit-clock cycle worth of counts removed, floored at zero
  function automatic logic [FIELD_W-1:0] gap_step(input logic [FIELD_W-1:0] cnt,
                                                  input logic ddr);
    logic [FIELD_W-1:0] s;
    s = ddr ? FIELD_W'(2) : FIELD_W'(1);
    return (cnt > s) ? cnt - s : '0;
  endfunction

  // value held after the issuing edge; zero is promoted to one count
  function automatic logic [FIELD_W-1:0] gap_seed(input logic [FIELD_W-1:0] val,
                                                  input logic ddr);
    logic [FIELD_W-1:0] v;
    v = (val == '0) ? FIELD_W'(1) : val;
    return gap_step(v, ddr);
  endfunction

  function automatic logic [FIELD_W-1:0] lat_cycles(input logic [FIELD_W-1:0] lat,
                                                    input logic ddr);
    return ddr ? (lat >> 1) : lat;
  endfunction

  function automatic logic lat_half(input logic [FIELD_W-1:0] lat, input logic ddr);
    return ddr & lat[0];
  endfunction
endpackage

// File: rtl/sdcmd_regs.sv
`timescale 1ns/1ps
module sdcmd_regs
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output timing_cfg_t      cfg,
  output logic             mode_en,
  output logic             cke_en,
  output logic             ddr_mode,
  output logic             pall_req,
  output logic             ref_req,
  output logic             wr_conflict,
  output logic             err_pulse
);
  logic wr_cfg, wr_ctl, gate_ok;

  assign wr_cfg      = reg_wr && !reg_sel;
  assign wr_ctl      = reg_wr && reg_sel;
  assign gate_ok     = mode_en && cke_en;
  assign wr_conflict = wr_ctl && reg_wdata[3] && reg_wdata[4];
  assign pall_req    = wr_ctl && reg_wdata[4] && !reg_wdata[3] && gate_ok;
  assign ref_req     = wr_ctl && reg_wdata[3] && !reg_wdata[4] && gate_ok;

  // timing register: power-up reset only
  always_ff @(posedge clk) begin
    if (!por_n)      cfg <= '0;
    else if (wr_cfg) cfg <= reg_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      mode_en   <= 1'b0;
      cke_en    <= 1'b0;
      ddr_mode  <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= wr_conflict;
      if (wr_ctl) begin
        mode_en  <= reg_wdata[0];
        cke_en   <= reg_wdata[1];
        ddr_mode <= reg_wdata[2];
      end
    end
  end

  assign reg_rdata = reg_sel ? REG_W'({ddr_mode, cke_en, mode_en}) : REG_W'(cfg);
endmodule

// File: rtl/sdcmd_gap_timer.sv
`timescale 1ns/1ps
module sdcmd_gap_timer
  import sdcmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ddr,
  input  logic               load,
  input  logic [FIELD_W-1:0] load_val,
  output logic               done
);
  logic [FIELD_W-1:0] cnt_q, dec, seed, cnt_d;

  always_comb begin
    dec   = gap_step(cnt_q, ddr);
    seed  = gap_seed(load_val, ddr);
    cnt_d = (load && (seed > dec)) ? seed : dec;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sdcmd_lat_pipe.sv
`timescale 1ns/1ps
module sdcmd_lat_pipe
  import sdcmd_pkg::*;
#(
  parameter int DEPTH = (1 << FIELD_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [FIELD_W-1:0] dly,
  output logic               strobe
);
  // bit k: strobe due after k+1 more edges
  logic [DEPTH-1:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d = pipe_q >> 1;
    if (fire && (dly != '0))
      pipe_d = pipe_d | (DEPTH'(1) << (dly - FIELD_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
      strobe <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      strobe <= (fire && (dly == '0)) || pipe_q[0];
    end
  end
endmodule

// File: rtl/sdcmd_gap_unit.sv
`timescale 1ns/1ps
module sdcmd_gap_unit
  import sdcmd_pkg::*;
#(
  parameter int N_CS   = 2,
  localparam int RANK_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [RANK_W-1:0] req_rank,
  output logic              req_ready,
  output logic [N_CS-1:0]   cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              a10,
  output logic              cke,
  output logic              rd_strobe,
  output logic              rd_half,
  output logic              wr_strobe,
  output logic              wr_half,
  output logic              cmd_err
);
  timing_cfg_t cfg;
  logic mode_en, ddr_mode, pall_req, ref_req, wr_conflict;
  logic sys_rst;
  logic pall_pend, ref_pend, pall_fire, ref_fire, pend_any;
  logic gap_ok, up_iss;
  logic ev_act, ev_rd, ev_wr, ev_pre, ev_ref;
  logic [N_TM-1:0] t_done, t_load;
  logic [FIELD_W-1:0] t_val [N_TM];

  assign sys_rst = !por_n || !rst_n;

  sdcmd_regs u_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg(cfg), .mode_en(mode_en), .cke_en(cke), .ddr_mode(ddr_mode),
    .pall_req(pall_req), .ref_req(ref_req), .wr_conflict(wr_conflict),
    .err_pulse(cmd_err)
  );

  // manual requests wait for their own gap, precharge-all first
  always_ff @(posedge clk) begin
    if (sys_rst) begin
      pall_pend <= 1'b0;
      ref_pend  <= 1'b0;
    end else begin
      if (pall_req)       pall_pend <= 1'b1;
      else if (pall_fire) pall_pend <= 1'b0;
      if (ref_req)        ref_pend  <= 1'b1;
      else if (ref_fire)  ref_pend  <= 1'b0;
    end
  end

  assign pall_fire = pall_pend && t_done[TM_PRE];
  assign ref_fire  = ref_pend && !pall_pend && t_done[TM_REF];
  assign pend_any  = pall_pend || ref_pend;

  always_comb begin
    case (req_cmd)
      CMD_ACT:         gap_ok = t_done[TM_ACT];
      CMD_RD, CMD_WR:  gap_ok = t_done[TM_RW];
      CMD_PRE:         gap_ok = t_done[TM_PRE];
      CMD_REF:         gap_ok = t_done[TM_REF];
      default:         gap_ok = 1'b1;
    endcase
  end

  assign req_ready = cke && !pend_any && gap_ok;
  assign up_iss    = req_valid && req_ready &&
                     (req_cmd >= CMD_ACT) && (req_cmd <= CMD_REF);

  assign ev_act = up_iss && (req_cmd == CMD_ACT);
  assign ev_rd  = up_iss && (req_cmd == CMD_RD);
  assign ev_wr  = up_iss && (req_cmd == CMD_WR);
  assign ev_pre = (up_iss && (req_cmd == CMD_PRE)) || pall_fire;
  assign ev_ref = (up_iss && (req_cmd == CMD_REF)) || ref_fire;

  // which events start which gap (one command per cycle, so sources never collide)
  always_comb begin
    t_load[TM_RW]  = ev_act || ev_ref;
    t_val[TM_RW]   = ev_ref ? cfg.ref2any : cfg.act2rw;
    t_load[TM_PRE] = ev_rd || ev_wr || ev_ref;
    t_val[TM_PRE]  = ev_ref ? cfg.ref2any : cfg.rw2pre;
    t_load[TM_ACT] = ev_pre || ev_ref;
    t_val[TM_ACT]  = ev_ref ? cfg.ref2any : cfg.pre2act;
    t_load[TM_REF] = ev_pre || ev_ref;
    t_val[TM_REF]  = ev_ref ? cfg.ref2any : cfg.pre2act;
  end

  for (genvar i = 0; i < N_TM; i++) begin : g_tm
    sdcmd_gap_timer u_tm (
      .clk(clk), .rst(sys_rst), .ddr(ddr_mode),
      .load(t_load[i]), .load_val(t_val[i]), .done(t_done[i])
    );
  end

  // data strobes: channel 0 read, channel 1 write
  logic [1:0] lp_fire, lp_strobe;
  logic [FIELD_W-1:0] lp_lat [2];
  assign lp_fire   = {ev_wr, ev_rd};
  assign lp_lat[0] = cfg.rd_lat;
  assign lp_lat[1] = cfg.wr_lat;

  for (genvar c = 0; c < 2; c++) begin : g_lat
    sdcmd_lat_pipe u_pipe (
      .clk(clk), .rst(sys_rst), .fire(lp_fire[c]),
      .dly(lat_cycles(lp_lat[c], ddr_mode)), .strobe(lp_strobe[c])
    );
  end

  assign rd_strobe = lp_strobe[0];
  assign wr_strobe = lp_strobe[1];
  assign rd_half   = lp_strobe[0] && lat_half(cfg.rd_lat, ddr_mode);
  assign wr_half   = lp_strobe[1] && lat_half(cfg.wr_lat, ddr_mode);

  // command pins, registered
  logic [N_CS-1:0] cs_d;
  logic [2:0]      rcw_d;
  logic            a10_d;

  always_comb begin
    cs_d  = '1;
    rcw_d = 3'b111;
    a10_d = 1'b0;
    if (pall_fire) begin
      cs_d  = '0;
      rcw_d = 3'b010;
      a10_d = 1'b1;
    end else if (ref_fire) begin
      cs_d  = '0;
      rcw_d = 3'b001;
    end else if (up_iss) begin
      cs_d = ~(N_CS'(1) << req_rank);
      case (req_cmd)
        CMD_ACT: rcw_d = 3'b011;
        CMD_RD:  rcw_d = 3'b101;
        CMD_WR:  rcw_d = 3'b100;
        CMD_PRE: rcw_d = 3'b010;
        default: rcw_d = 3'b001;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      cs_n                 <= '1;
      {ras_n, cas_n, we_n} <= 3'b111;
      a10                  <= 1'b0;
    end else begin
      cs_n                 <= cs_d;
      {ras_n, cas_n, we_n} <= rcw_d;
      a10                  <= a10_d;
    end
  end
endmodule

// File: rtl/sdcmd_gap_sva.sv
`timescale 1ns/1ps
module sdcmd_gap_sva
  import sdcmd_pkg::*;
#(
  parameter int N_CS = 2
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic             wd_ref,
  input logic             wd_pall,
  input logic [1:0]       rd_wo,
  input logic             req_valid,
  input logic             req_ready,
  input logic [N_CS-1:0]  cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             a10,
  input logic             cmd_err,
  input logic             mode_en,
  input logic             cke,
  input logic             pall_pend,
  input logic             ref_pend,
  input logic             pall_fire,
  input logic             ref_fire,
  input logic             wr_conflict,
  input logic [CFG_W-1:0] cfg_bits
);
  AST_WO_BITS_ZERO: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    reg_sel |-> (rd_wo == 2'b00)); // R1

  AST_CFG_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    !(reg_wr && !reg_sel) |=> $stable(cfg_bits)); // R2

  AST_GATED_IGNORE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (reg_wr && reg_sel && wd_pall && !wd_ref && !(mode_en && cke) && !pall_pend)
      |=> !pall_pend); // R7

  AST_PALL_PINS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    pall_fire |=> (cs_n == '0) && !ras_n && cas_n && !we_n && a10); // R8

  AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_conflict && !pall_pend && !ref_pend) |=> (cmd_err && !pall_pend && !ref_pend)); // R9

  AST_HELD_IDLE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (req_valid && !req_ready && !pall_fire && !ref_fire) |=> (&cs_n)); // R10
endmodule

bind sdcmd_gap_unit sdcmd_gap_sva #(.N_CS(N_CS)) u_sva (
  .clk(clk), .por_n(por_n), .rst_n(rst_n),
  .reg_wr(reg_wr), .reg_sel(reg_sel),
  .wd_ref(reg_wdata[3]), .wd_pall(reg_wdata[4]), .rd_wo(reg_rdata[4:3]),
  .req_valid(req_valid), .req_ready(req_ready),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10),
  .cmd_err(cmd_err), .mode_en(mode_en), .cke(cke),
  .pall_pend(pall_pend), .ref_pend(ref_pend),
  .pall_fire(pall_fire), .ref_fire(ref_fire),
  .wr_conflict(wr_conflict), .cfg_bits(cfg)
);

// File: tb/sdcmd_gap_unit_test.sv
`timescale 1ns/1ps
module sdcmd_gap_unit_test;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [0:0] req_rank = 1'b0;
  logic req_ready;
  logic [1:0] cs_n;
  logic ras_n, cas_n, we_n, a10, cke;
  logic rd_strobe, rd_half, wr_strobe, wr_half, cmd_err;

  int vectors = 0;
  int fails = 0;

  localparam logic [31:0] C_MODE = 32'd1, C_CKE = 32'd2, C_DDR = 32'd4,
                          C_REF = 32'd8, C_PALL = 32'd16;

  always #4 clk = ~clk;

  sdcmd_gap_unit uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_rank(req_rank), .req_ready(req_ready),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10), .cke(cke),
    .rd_strobe(rd_strobe), .rd_half(rd_half), .wr_strobe(wr_strobe), .wr_half(wr_half),
    .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic sel, output logic [31:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic issue(input logic [2:0] c, input logic r);
    req_cmd = c; req_rank = r; req_valid = 1'b1; #1;
    for (int k = 0; k < 40 && !req_ready; k++) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0; #1;
  endtask

  task automatic gap_run(input logic [2:0] c1, input logic [2:0] c2, output int n);
    issue(c1, 1'b0);
    req_cmd = c2; req_valid = 1'b1; #1; n = 1;
    while (!req_ready && n < 40) begin @(negedge clk); #1; n++; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // counts cycles with every chip select low, records pins of the first
  task automatic scan_all(input int len, output int cnt, output logic [3:0] pins);
    cnt = 0; pins = '0;
    for (int k = 0; k < len; k++) begin
      #1;
      if (cs_n == 2'b00) begin
        if (cnt == 0) pins = {ras_n, cas_n, we_n, a10};
        cnt++;
      end
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    vectors++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n, exp, cnt;
    logic [3:0] pins;
    logic [2:0] c1 [4];
    logic [2:0] c2 [4];
    c1[0] = 3'd1; c2[0] = 3'd2;
    c1[1] = 3'd2; c2[1] = 3'd4;
    c1[2] = 3'd4; c2[2] = 3'd1;
    c1[3] = 3'd5; c2[3] = 3'd1;

    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk); #1;
    // R2 reset state
    chk(cs_n == 2'b11 && {ras_n, cas_n, we_n} == 3'b111 && !a10, "R2 pins idle", {cs_n, ras_n, cas_n, we_n}, 31);
    chk(!cke && !req_ready, "R2 cke/ready low", {cke, req_ready}, 0);
    rd_reg(1'b0, d); chk(d == 0, "R2 timing reg reset", d, 0);
    rd_reg(1'b1, d); chk(d == 0, "R2 control reg reset", d, 0);

    // R1 masks and readback
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, d); chk(d == 32'h00FF_FFFF, "R1 timing readback", d, 32'h00FF_FFFF);
    wr_reg(1'b1, C_MODE | C_CKE);
    wr_reg(1'b1, C_MODE | C_CKE | C_PALL);
    rd_reg(1'b1, d); chk(d == 32'd3, "R1 request bit reads zero", d, 3);
    idle(20);

    // R11 pin encodings, both ranks
    wr_reg(1'b0, 32'h0011_1100);
    for (int r = 0; r < 2; r++) begin
      int pat [5];
      pat[0] = 3; pat[1] = 5; pat[2] = 4; pat[3] = 2; pat[4] = 1;
      for (int c = 1; c <= 5; c++) begin
        idle(20);
        issue(3'(c), 1'(r));
        chk(cs_n == ~(2'b01 << r) && {ras_n, cas_n, we_n} == 3'(pat[c-1]) && !a10,
            "R11 pins", {cs_n, ras_n, cas_n, we_n}, {~(2'b01 << r), 3'(pat[c-1])});
      end
    end

    // R3 R4 R5 gap sweep over every field value in both modes
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 16; f++) begin
        wr_reg(1'b0, {8'h00, {4{4'(f)}}, 8'h00});
        wr_reg(1'b1, C_MODE | C_CKE | (m != 0 ? C_DDR : 0));
        for (int p = 0; p < 4; p++) begin
          idle(20);
          gap_run(c1[p], c2[p], n);
          exp = ((f == 0 ? 1 : f) + m) / (m + 1);
          if (f == 0)      chk(n == exp, "R5 zero field gap", n, exp);
          else if (m == 0) chk(n == exp, "R3 single-rate gap", n, exp);
          else             chk(n == exp, "R4 double-rate gap", n, exp);
        end
      end
    end

    // R6 latency sweep
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 16; l++) begin
        wr_reg(1'b0, {8'h00, 16'h1111, 4'(15 - l), 4'(l)});
        wr_reg(1'b1, C_MODE | C_CKE | (m != 0 ? C_DDR : 0));
        idle(20);
        issue(3'd1, 1'b0);
        issue(3'd2, 1'b0);
        n = 0;
        while (!rd_strobe && n < 40) begin @(negedge clk); #1; n++; end
        exp = (m != 0) ? (l / 2) : l;
        chk(n == exp, "R6 read strobe delay", n, exp);
        chk(rd_half == ((m != 0) && (l % 2 == 1)), "R6 read half flag", rd_half, (m != 0) && (l % 2 == 1));
        @(negedge clk); #1;
        chk(!rd_strobe, "R6 read strobe single", rd_strobe, 0);
        idle(20);
        issue(3'd3, 1'b0);
        n = 0;
        while (!wr_strobe && n < 40) begin @(negedge clk); #1; n++; end
        exp = (m != 0) ? ((15 - l) / 2) : (15 - l);
        chk(n == exp, "R6 write strobe delay", n, exp);
        chk(wr_half == ((m != 0) && (l % 2 == 0)), "R6 write half flag", wr_half, (m != 0) && (l % 2 == 0));
        @(negedge clk); #1;
        chk(!wr_strobe, "R6 write strobe single", wr_strobe, 0);
      end
    end

    // R7 gating: enable off, then clock enable only just being set
    wr_reg(1'b0, 32'h0011_1100);
    wr_reg(1'b1, C_CKE);
    idle(20);
    wr_reg(1'b1, C_CKE | C_PALL);
    scan_all(10, cnt, pins); chk(cnt == 0, "R7 ignored without enable", cnt, 0);
    req_cmd = 3'd1; req_valid = 1'b0; #1;
    chk(req_ready, "R7 ready unaffected", req_ready, 1);
    wr_reg(1'b1, C_MODE);
    wr_reg(1'b1, C_MODE | C_CKE | C_REF);
    scan_all(10, cnt, pins); chk(cnt == 0, "R7 ignored with clock enable off", cnt, 0);

    // R8 honored precharge-all
    wr_reg(1'b1, C_MODE | C_CKE | C_PALL);
    scan_all(10, cnt, pins);
    chk(cnt == 1, "R8 one all-rank cycle", cnt, 1);
    chk(pins == 4'b0101, "R8 precharge-all pins", pins, 4'b0101);

    // R12 honored refresh
    idle(20);
    wr_reg(1'b1, C_MODE | C_CKE | C_REF);
    scan_all(10, cnt, pins);
    chk(cnt == 1, "R12 one all-rank cycle", cnt, 1);
    chk(pins == 4'b0010, "R12 refresh pins", pins, 4'b0010);

    // R9 conflict
    idle(20);
    wr_reg(1'b1, C_MODE | C_CKE | C_REF | C_PALL);
    #1; chk(cmd_err, "R9 error pulse", cmd_err, 1);
    @(negedge clk); #1; chk(!cmd_err, "R9 error one cycle", cmd_err, 0);
    scan_all(10, cnt, pins); chk(cnt == 0, "R9 neither command", cnt, 0);

    // R10 pending manual request blocks upstream and waits for its gap
    wr_reg(1'b0, 32'h0011_F100);
    wr_reg(1'b1, C_MODE | C_CKE);
    idle(20);
    issue(3'd2, 1'b0);
    wr_reg(1'b1, C_MODE | C_CKE | C_PALL);
    req_cmd = 3'd2; #1;
    chk(!req_ready, "R10 upstream held while pending", req_ready, 0);
    chk(cs_n == 2'b11, "R10 no early precharge-all", cs_n, 3);
    scan_all(25, cnt, pins);
    chk(cnt == 1 && pins == 4'b0101, "R10 precharge-all after gap", {cnt, pins}, 21);
    #1; chk(req_ready, "R10 ready after release", req_ready, 1);

    // R2 system reset keeps timing, power-up reset clears it
    wr_reg(1'b0, 32'h00A5_C3E7);
    rst_n = 1'b0; idle(2); rst_n = 1'b1;
    rd_reg(1'b0, d); chk(d == 32'h00A5_C3E7, "R2 timing survives system reset", d, 32'h00A5_C3E7);
    rd_reg(1'b1, d); chk(d == 0 && !cke, "R2 control cleared", d, 0);
    por_n = 1'b0; idle(2); por_n = 1'b1;
    rd_reg(1'b0, d); chk(d == 0, "R2 power-up clears timing", d, 0);

    finish_run();
  end
endmodule